// File: doc/BRIEF.md
# Indirect Wide-Register Access Unit

This unit runs three operations against a bank of 32 wide registers of 256 bits each: a wide load from a small data memory, a wide store into it, and a wide register-to-register move. None of them takes its wide register number from the instruction. Each one reads the number at run time out of a 32-bit general-purpose register (GPR) value that the caller supplies. The caller also supplies the increment flags and an immediate offset.

An operation is offered with `op_valid_i` while `op_ready_o` is high, and it is captured at that clock edge. In the next cycle the unit checks the indices, the flags and the memory address. If any check fails, it pulses the error bits and commits nothing. If the checks pass, it performs the register or memory write and reports one post-incremented GPR value for the caller to write back. A successful load spends one extra stall cycle so that the memory data can be written into the wide register.

Operand roles depend on the operation:

| Operation | `gpr_a_i` | `gpr_b_i` | `inc_a_i` adds | `inc_b_i` adds |
|-----------|-----------|-----------|----------------|----------------|
| Load | byte base address | destination wide register number | 32 | 1 |
| Store | byte base address | source wide register number | 32 | 1 |
| Move | source wide register number | destination wide register number | 1 | 1 |

The memory starts from reset with word `i` holding the 32-bit value `0xC0DE0000 + i` repeated eight times. The wide registers start at zero.

Top module: `widx_unit`

## Requirements
- R1: After reset, `op_ready_o` is 1, `done_o`, `err_illegal_o`, `err_addr_o` and `gpr_we_o` are 0, and every wide register reads 0 on the read port (`rd_idx_i` → `rd_data_o`, combinational).
- R2: A load (`op_kind_i` = 0) without a fault writes memory word `addr/32` into wide register `gpr_b_i[4:0]`. It asserts `done_o` two cycles after the accepting edge.
- R3: A store (`op_kind_i` = 1) without a fault writes wide register `gpr_b_i[4:0]` into memory word `addr/32`. It asserts `done_o` one cycle after the accepting edge.
- R4: A move (`op_kind_i` = 2) without a fault copies wide register `gpr_a_i[4:0]` into wide register `gpr_b_i[4:0]`. It asserts `done_o` one cycle after the accepting edge.
- R5: An index value with any of bits 31:5 set raises `err_illegal_o`. For a load or a store the index is `gpr_b_i`. For a move it is either `gpr_a_i` or `gpr_b_i`.
- R6: Setting both `inc_a_i` and `inc_b_i`, or using `op_kind_i` = 3, raises `err_illegal_o`.
- R7: For a load or a store, an address that is not a multiple of 32, or is not below `DMEM_WORDS*32`, raises `err_addr_o`. When an illegal condition is also present, both error bits are set in the same cycle.
- R8: A faulting operation pulses its error bits together with `done_o`, one cycle after acceptance. It writes no memory word and no wide register, and it keeps `gpr_we_o` low.
- R9: An index increment reports the old value plus 1 with no masking, so 31 becomes 32. `gpr_sel_o` = 1 selects `gpr_b_i` and `gpr_sel_o` = 0 selects `gpr_a_i`.
- R10: An address-pointer increment on a load or a store reports `gpr_a_i + 32` modulo 2^32 on `gpr_sel_o` = 0.
- R11: The memory address is `gpr_a_i + offset_i` modulo 2^32.
- R12: `op_ready_o` is low from the cycle after acceptance until `done_o` has been seen. `done_o` lasts exactly one cycle, and `op_ready_o` is high again in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Operation offered |
| op_ready_o | output | 1 | Unit idle and able to accept an operation |
| op_kind_i | input | 2 | Operation code: 0 load, 1 store, 2 move |
| inc_a_i | input | 1 | Post-increment the GPR given on `gpr_a_i` |
| inc_b_i | input | 1 | Post-increment the GPR given on `gpr_b_i` |
| gpr_a_i | input | 32 | Base address (load, store) or source index (move) |
| gpr_b_i | input | 32 | Wide register index: destination for load and move, source for store |
| offset_i | input | 32 | Immediate byte offset |
| done_o | output | 1 | Operation finished or faulted |
| err_illegal_o | output | 1 | Illegal-instruction error pulse |
| err_addr_o | output | 1 | Bad-data-address error pulse |
| gpr_we_o | output | 1 | GPR writeback valid |
| gpr_sel_o | output | 1 | Writeback target: 0 for the `gpr_a_i` register, 1 for the `gpr_b_i` register |
| gpr_wdata_o | output | 32 | Post-incremented GPR value |
| rd_idx_i | input | 5 | Wide register read-port index |
| rd_data_o | output | 256 | Wide register read-port data |

## Verification
Stores, moves and every faulting operation report one cycle after the accepting edge. Their `done_o`, error bits and writeback value all appear in that cycle. A clean load reports one cycle later, and its wide register holds the new data only after that second cycle has closed. The bench offers each operation on a falling edge and then samples at each following falling edge. It counts the edges until `done_o` appears and compares that count with the latency the vector expects, so a result that is early or late is reported as a mismatch. Wide register and memory contents are read back only after `done_o` has been seen: directly through the read port, or for memory through a later load.

// File: rtl/widx_unit.sv
module widx_unit #(
  parameter int DMEM_WORDS = 16,
  parameter int WLEN       = 256,
  parameter int NREGS      = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  output logic            op_ready_o,
  input  logic [1:0]      op_kind_i,
  input  logic            inc_a_i,
  input  logic            inc_b_i,
  input  logic [31:0]     gpr_a_i,
  input  logic [31:0]     gpr_b_i,
  input  logic [31:0]     offset_i,
  output logic            done_o,
  output logic            err_illegal_o,
  output logic            err_addr_o,
  output logic            gpr_we_o,
  output logic            gpr_sel_o,
  output logic [31:0]     gpr_wdata_o,
  input  logic [4:0]      rd_idx_i,
  output logic [WLEN-1:0] rd_data_o
);
  localparam int WBYTES = WLEN / 8;
  localparam int OFFW   = $clog2(WBYTES);
  localparam int AW     = $clog2(DMEM_WORDS);
  localparam logic [31:0] MEM_BYTES = 32'(DMEM_WORDS * WBYTES);
  localparam logic [1:0] K_LOAD = 2'd0, K_STORE = 2'd1, K_MOVE = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_STALL} state_e;
  state_e state_q;

  logic [1:0]      kind_q;
  logic            inc_a_q, inc_b_q;
  logic [31:0]     a_q, b_q, off_q;
  logic [WLEN-1:0] ld_q;
  logic [WLEN-1:0] wreg [NREGS];
  logic [WLEN-1:0] mem  [DMEM_WORDS];

  logic [31:0]   addr;
  logic [AW-1:0] widx;
  logic          mem_op, ill, addr_bad, fault, exec_done, commit;

  assign addr     = a_q + off_q;
  assign widx     = addr[OFFW +: AW];
  assign mem_op   = (kind_q == K_LOAD) || (kind_q == K_STORE);
  assign ill      = (inc_a_q & inc_b_q) | (kind_q == 2'd3) | (|b_q[31:5])
                  | ((kind_q == K_MOVE) & (|a_q[31:5]));
  assign addr_bad = mem_op & ((addr[OFFW-1:0] != '0) | (addr >= MEM_BYTES));
  assign fault    = ill | addr_bad;

  assign exec_done  = (state_q == S_EXEC) & ~((kind_q == K_LOAD) & ~fault);
  assign done_o     = exec_done | (state_q == S_STALL);
  assign op_ready_o = (state_q == S_IDLE);
  assign err_illegal_o = (state_q == S_EXEC) & ill;
  assign err_addr_o    = (state_q == S_EXEC) & addr_bad;

  assign commit      = done_o & ~err_illegal_o & ~err_addr_o;
  assign gpr_we_o    = commit & (inc_a_q | inc_b_q);
  assign gpr_sel_o   = inc_b_q;
  assign gpr_wdata_o = inc_b_q ? b_q + 32'd1
                     : (kind_q == K_MOVE) ? a_q + 32'd1 : a_q + 32'(WBYTES);
  assign rd_data_o   = wreg[rd_idx_i];

  logic wreg_we;
  assign wreg_we = commit & (kind_q != K_STORE);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= '0;
      inc_a_q <= 1'b0;
      inc_b_q <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      off_q   <= '0;
      ld_q    <= '0;
      for (int i = 0; i < NREGS; i++) wreg[i] <= '0;
      for (int i = 0; i < DMEM_WORDS; i++) mem[i] <= {(WLEN/32){32'hC0DE0000 + 32'(i)}};
    end else begin
      unique case (state_q)
        S_IDLE: if (op_valid_i) begin
          state_q <= S_EXEC;
          kind_q  <= op_kind_i;
          inc_a_q <= inc_a_i;
          inc_b_q <= inc_b_i;
          a_q     <= gpr_a_i;
          b_q     <= gpr_b_i;
          off_q   <= offset_i;
        end
        S_EXEC: begin
          state_q <= exec_done ? S_IDLE : S_STALL;
          ld_q    <= mem[widx];
          if (!fault && kind_q == K_STORE) mem[widx] <= wreg[b_q[4:0]];
          if (!fault && kind_q == K_MOVE)  wreg[b_q[4:0]] <= wreg[a_q[4:0]];
        end
        default: begin
          state_q <= S_IDLE;
          wreg[b_q[4:0]] <= ld_q;
        end
      endcase
    end
  end

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && op_ready_o);
  assert_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_ready_o && op_valid_i) |=> !op_ready_o);
  assert_fault_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_illegal_o || err_addr_o) |-> done_o && !gpr_we_o && !wreg_we);
  assert_load_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EXEC && kind_q == K_LOAD && !fault) |=> done_o && !err_illegal_o);
  assert_err_timing_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_illegal_o || err_addr_o) |-> $past(op_ready_o && op_valid_i));
endmodule

// File: tb/widx_unit_test.sv
module widx_unit_test;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n, valid, ready, ia, ib, done, ill, bad, we, sel;
  logic [1:0] kind;
  logic [31:0] a, b, off, wd;
  logic [4:0] ridx;
  logic [255:0] rdata;

  widx_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(valid), .op_ready_o(ready),
    .op_kind_i(kind), .inc_a_i(ia), .inc_b_i(ib), .gpr_a_i(a), .gpr_b_i(b),
    .offset_i(off), .done_o(done), .err_illegal_o(ill), .err_addr_o(bad),
    .gpr_we_o(we), .gpr_sel_o(sel), .gpr_wdata_o(wd), .rd_idx_i(ridx), .rd_data_o(rdata));

  int checks = 0, fails = 0;

  typedef struct packed {
    logic [1:0] kind; logic ia, ib;
    logic [31:0] a, b, off;
    logic ill, bad, we, sel;
    logic [31:0] wd;
    logic [1:0] lat;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'd0,1'b0,1'b0,32'h40,32'd5,32'h0,       1'b0,1'b0,1'b0,1'b0,32'h0,2'd2},
    '{2'd0,1'b0,1'b1,32'h20,32'd31,32'h20,     1'b0,1'b0,1'b1,1'b1,32'd32,2'd2},
    '{2'd0,1'b0,1'b1,32'h0,32'd32,32'h0,       1'b1,1'b0,1'b0,1'b0,32'h0,2'd1},
    '{2'd0,1'b0,1'b0,32'h10,32'd3,32'h0,       1'b0,1'b1,1'b0,1'b0,32'h0,2'd1},
    '{2'd0,1'b0,1'b0,32'h200,32'd3,32'h0,      1'b0,1'b1,1'b0,1'b0,32'h0,2'd1},
    '{2'd0,1'b1,1'b0,32'h204,32'd40,32'h0,     1'b1,1'b1,1'b0,1'b0,32'h0,2'd1},
    '{2'd1,1'b1,1'b0,32'h60,32'd5,32'h0,       1'b0,1'b0,1'b1,1'b0,32'h80,2'd1},
    '{2'd1,1'b1,1'b1,32'h0,32'd1,32'h0,        1'b1,1'b0,1'b0,1'b0,32'h0,2'd1},
    '{2'd2,1'b1,1'b0,32'd5,32'd7,32'h0,        1'b0,1'b0,1'b1,1'b0,32'd6,2'd1},
    '{2'd2,1'b0,1'b0,32'd33,32'd7,32'h0,       1'b1,1'b0,1'b0,1'b0,32'h0,2'd1},
    '{2'd2,1'b0,1'b0,32'd5,32'h100,32'h0,      1'b1,1'b0,1'b0,1'b0,32'h0,2'd1},
    '{2'd2,1'b0,1'b1,32'd31,32'd8,32'h0,       1'b0,1'b0,1'b1,1'b1,32'd9,2'd1},
    '{2'd0,1'b1,1'b0,32'hFFFFFFF0,32'd9,32'h30,1'b0,1'b0,1'b1,1'b0,32'h10,2'd2},
    '{2'd1,1'b1,1'b0,32'hFFFFFFE0,32'd0,32'h0, 1'b0,1'b1,1'b0,1'b0,32'h0,2'd1}
  };

  function automatic logic [255:0] initw(int i);
    return {8{32'hC0DE0000 + 32'(i)}};
  endfunction

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic o_ill, o_bad, o_we, o_sel;
  logic [31:0] o_wd;
  int o_lat;

  task automatic run_op(logic [1:0] k, logic fa, logic fb, logic [31:0] va, logic [31:0] vb,
                        logic [31:0] vo);
    @(negedge clk);
    kind = k; ia = fa; ib = fb; a = va; b = vb; off = vo; valid = 1;
    @(negedge clk);
    valid = 0;
    check("R12 ready low while busy", ready, 1'b0);
    o_lat = 1;
    while (!done && o_lat < 5) begin
      @(negedge clk);
      o_lat++;
    end
    o_ill = ill; o_bad = bad; o_we = we; o_sel = sel; o_wd = wd;
    @(negedge clk);
    check("R12 done single cycle", done, 1'b0);
    check("R12 ready after done", ready, 1'b1);
  endtask

  task automatic read_wreg(int idx, logic [255:0] exp, string req);
    @(negedge clk);
    ridx = 5'(idx);
    #1;
    check(req, rdata, exp);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; valid = 0; kind = 0; ia = 0; ib = 0; a = 0; b = 0; off = 0; ridx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R1 ready", ready, 1'b1);
    check("R1 done", done, 1'b0);
    check("R1 errors", {ill, bad, we}, 3'b0);
    read_wreg(0, '0, "R1 wide reg zero");
    read_wreg(17, '0, "R1 wide reg zero");

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i].kind, VEC[i].ia, VEC[i].ib, VEC[i].a, VEC[i].b, VEC[i].off);
      check("R2 R3 R4 R8 latency", o_lat, VEC[i].lat);
      check("R5 R6 illegal", o_ill, VEC[i].ill);
      check("R7 R11 bad address", o_bad, VEC[i].bad);
      check("R8 writeback enable", o_we, VEC[i].we);
      if (VEC[i].we) begin
        check("R9 R10 writeback select", o_sel, VEC[i].sel);
        check("R9 R10 R11 writeback value", o_wd, VEC[i].wd);
      end
    end

    read_wreg(5, initw(2), "R2 load data");
    read_wreg(31, initw(2), "R2 R11 load with offset");
    read_wreg(7, initw(2), "R4 move data");
    read_wreg(8, initw(2), "R4 move from 31");
    read_wreg(9, initw(1), "R11 wrapped address load");
    read_wreg(3, '0, "R8 faulted load left register");
    read_wreg(0, '0, "R8 illegal load left register");

    run_op(2'd0, 1'b0, 1'b0, 32'h60, 32'd10, 32'h0);
    read_wreg(10, initw(2), "R3 stored word reloaded");
    run_op(2'd0, 1'b0, 1'b0, 32'h0, 32'd11, 32'h0);
    read_wreg(11, initw(0), "R8 faulted store left memory");
    run_op(2'd1, 1'b0, 1'b0, 32'h1E0, 32'd31, 32'h0);
    check("R3 store at top word latency", o_lat, 1);
    run_op(2'd0, 1'b0, 1'b0, 32'h1C0, 32'd12, 32'h20);
    check("R7 top word in range", o_bad, 1'b0);
    read_wreg(12, initw(2), "R3 top word stored");
    run_op(2'd3, 1'b0, 1'b0, 32'd1, 32'd2, 32'h0);
    check("R6 kind 3 illegal", o_ill, 1'b1);
    read_wreg(2, '0, "R8 kind 3 no write");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule